// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

A cycle-accurate, synthesizable model of a synchronous pipelined static memory that accepts one new access, read or write, on every enabled clock. Reads and writes may alternate freely with no idle cycle. Every input is registered on the rising edge, and read data leaves through an output register. Write data reaches the shared data bus later than its address, so the write address and lane mask travel through a two-stage registry. A read that targets an address whose write data is still in flight is served from that pending data, merged lane by lane.

Each access is either a load, which takes a fresh address, or a burst continuation, which steps a 2-bit counter over the low address bits in linear or interleaved order. Each byte lane is 8 data bits plus one parity bit and has its own write select. The bus drivers turn on only in the data slot of a read, and only while output enable is high and the block is awake. A clock enable freezes the whole pipeline. An asynchronous active-low reset clears the pipeline and leaves the array contents untouched.

Top module: `nowait_sram`

## Requirements
- R1: The address and control of an access are captured at edge k. Its bus slot is the interval between edges k+1 and k+2. In the slot of a read, `dq_drv` is 1 and `dq` carries the stored word, provided `oe`=1 and `sleep`=0.
- R2: For a write captured at edge k, `dq` is sampled at edge k+2 and committed to the addressed word. A later read returns that value.
- R3: Accesses may alternate every cycle with no idle cycle. A read captured one edge after a write to the same address returns the new data, taken from the pending write.
- R4: Lane i occupies `dq[9i+8:9i]`, with parity in bit 9i+8. Only lanes with `lane_we[i]`=1 are written. Other lanes keep their previous contents, and a write with no lane selected changes nothing.
- R5: While `clk_en`=0, no pipeline, burst or array state changes and `dq` holds its value. Inputs presented during the stall are not captured.
- R6: On a continuation cycle (`adv`=1) after a load, `wr` and `cs` are ignored. The access keeps the kind of its load, the counter advances by one, and `lane_we` is taken fresh on every beat.
- R7: Beat n of a burst that starts at address S keeps the upper bits of S. Its low two bits are (S[1:0]+n) mod 4 when `order_lin`=1, and S[1:0] XOR n when `order_lin`=0.
- R8: `dq_drv` is 0 in the bus slot of a write, so the write data on the bus is never contended.
- R9: A load cycle with any bit of `cs` low is a deselect. It performs no access and leaves the bus undriven in its slot. A continuation that follows a deselect is also idle.
- R10: `oe`=0 forces `dq_drv` to 0 at once, without waiting for a clock edge.
- R11: While `sleep`=1, captured cycles are idle and `dq_drv` is 0. After sleep ends, the bus stays undriven until a new read reaches its slot, and the array contents are retained.
- R12: With `rst_n`=0, `dq_drv` is 0 and the pipeline holds no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low pipeline reset |
| clk_en | input | 1 | 1 = the edge advances state, 0 = the cycle is extended |
| cs | input | NUM_CS | Chip enables; all bits must be 1 for a load to select |
| adv | input | 1 | 0 = load a new address, 1 = continue the burst |
| wr | input | 1 | On a load: 1 = write, 0 = read |
| lane_we | input | LANES | Per-lane write selects, 1 = write that lane |
| order_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Low-power request, active high |
| addr | input | log2(DEPTH) | Word address |
| dq | inout | LANES*LANE_W | Shared bidirectional data bus |
| dq_drv | output | 1 | 1 while the block drives `dq` |

## Verification
The bench builds the block at its defaults: four lanes of nine bits, a 64-word array and three chip enables. With these values the bench can fill every word through the bus before the directed cases start. The parity bit in each lane exposes any mask bug that drops the ninth bit. A 64-word depth also leaves room for bursts whose four beats wrap inside an aligned group away from the other test addresses. Every read slot is compared against a reference memory updated at capture time, which exercises the registry bypass on each write-then-read turn.

// File: rtl/nws_pkg.sv
`timescale 1ns/1ps
package nws_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_RD   = 2'b01,
      OP_WR   = 2'b10
   } nws_op_e;

   // low address bits of beat 'cnt' of a burst starting at 'start'
   function automatic logic [1:0] beat_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       lin);
      logic [1:0] sum;
      sum = start + cnt;
      beat_low = lin ? sum : (start ^ cnt);
   endfunction

endpackage

// File: rtl/nws_burst.sv
`timescale 1ns/1ps
module nws_burst
   import nws_pkg::*;
#(
   parameter int AW    = 6,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en,
   input  logic             sel,
   input  logic             sleep,
   input  logic             adv,
   input  logic             wr,
   input  logic             order_lin,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] lane_we,
   output nws_op_e          op,
   output logic [AW-1:0]    op_addr,
   output logic [LANES-1:0] op_mask
);

   logic             act_q, act_d;
   logic             bwr_q, bwr_d;
   logic [AW-1:0]    base_q, base_d;
   logic [1:0]       cnt_q, cnt_d;
   nws_op_e          op_d;
   logic [AW-1:0]    addr_d;
   logic [LANES-1:0] mask_d;

   always_comb begin
      act_d  = act_q;
      bwr_d  = bwr_q;
      base_d = base_q;
      cnt_d  = cnt_q;
      op_d   = OP_IDLE;
      addr_d = op_addr;
      mask_d = '0;
      if (sleep) begin
         act_d = 1'b0;
      end else if (!adv) begin
         if (sel) begin
            act_d  = 1'b1;
            bwr_d  = wr;
            base_d = addr;
            cnt_d  = 2'd0;
            op_d   = wr ? OP_WR : OP_RD;
            addr_d = addr;
         end else begin
            act_d = 1'b0;
         end
      end else if (act_q) begin
         cnt_d  = cnt_q + 2'd1;
         op_d   = bwr_q ? OP_WR : OP_RD;
         addr_d = {base_q[AW-1:2], beat_low(base_q[1:0], cnt_d, order_lin)};
      end
      if (op_d == OP_WR) mask_d = lane_we;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         bwr_q   <= 1'b0;
         base_q  <= '0;
         cnt_q   <= 2'd0;
         op      <= OP_IDLE;
         op_addr <= '0;
         op_mask <= '0;
      end else if (clk_en) begin
         act_q   <= act_d;
         bwr_q   <= bwr_d;
         base_q  <= base_d;
         cnt_q   <= cnt_d;
         op      <= op_d;
         op_addr <= addr_d;
         op_mask <= mask_d;
      end
   end

   p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && adv && act_q && !sleep |=> cnt_q == $past(cnt_q) + 2'd1);

   p_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && adv && act_q && !sleep |=> op == ($past(bwr_q) ? OP_WR : OP_RD));

   p_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && adv && act_q && !sleep |=> op_addr[AW-1:2] == $past(base_q[AW-1:2]));

   p_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && !adv && !sel |=> op == OP_IDLE);

   p_sleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && sleep |=> op == OP_IDLE && !act_q);

   p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> $stable(op_addr) && $stable(cnt_q) && $stable(act_q));

endmodule

// File: rtl/nws_lane.sv
`timescale 1ns/1ps
module nws_lane #(
   parameter int AW    = 6,
   parameter int W     = 9,
   parameter int DEPTH = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   input  logic          byp,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // pending write for this lane wins over the stale array word
   assign rdata = byp ? wdata : mem[raddr];

   p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/nowait_sram.sv
`timescale 1ns/1ps
module nowait_sram
   import nws_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int DEPTH  = 64,
   parameter int NUM_CS = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clk_en,
   input  logic [NUM_CS-1:0]           cs,
   input  logic                        adv,
   input  logic                        wr,
   input  logic [LANES-1:0]            lane_we,
   input  logic                        order_lin,
   input  logic                        oe,
   input  logic                        sleep,
   input  logic [$clog2(DEPTH)-1:0]    addr,
   inout  wire  [LANES*LANE_W-1:0]     dq,
   output logic                        dq_drv
);

   localparam int AW = $clog2(DEPTH);
   localparam int DW = LANES * LANE_W;

   generate
      if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 8");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("LANES and LANE_W must be positive");
      end
      if (NUM_CS < 1) begin : g_bad_cs
         $error("NUM_CS must be positive");
      end
   endgenerate

   nws_op_e          s1_op, s2_op;
   logic [AW-1:0]    s1_addr, s2_addr;
   logic [LANES-1:0] s1_mask, s2_mask;
   logic [DW-1:0]    rd_word, q_reg;
   logic             drv_reg;
   logic             s2_wr, s2_hit;

   nws_burst #(.AW(AW), .LANES(LANES)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_en   (clk_en),
      .sel      (&cs),
      .sleep    (sleep),
      .adv      (adv),
      .wr       (wr),
      .order_lin(order_lin),
      .addr     (addr),
      .lane_we  (lane_we),
      .op       (s1_op),
      .op_addr  (s1_addr),
      .op_mask  (s1_mask)
   );

   assign s2_wr  = (s2_op == OP_WR);
   assign s2_hit = s2_wr && (s2_addr == s1_addr);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         nws_lane #(.AW(AW), .W(LANE_W), .DEPTH(DEPTH)) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (clk_en && s2_wr && s2_mask[g]),
            .waddr(s2_addr),
            .wdata(dq[g*LANE_W +: LANE_W]),
            .raddr(s1_addr),
            .byp  (s2_hit && s2_mask[g]),
            .rdata(rd_word[g*LANE_W +: LANE_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_op   <= OP_IDLE;
         s2_addr <= '0;
         s2_mask <= '0;
         q_reg   <= '0;
         drv_reg <= 1'b0;
      end else if (clk_en) begin
         s2_op   <= s1_op;
         s2_addr <= s1_addr;
         s2_mask <= s1_mask;
         if (s1_op == OP_RD) begin
            q_reg   <= rd_word;
            drv_reg <= 1'b1;
         end else begin
            drv_reg <= 1'b0;
         end
      end
   end

   assign dq_drv = drv_reg & oe & ~sleep & rst_n;
   assign dq     = dq_drv ? q_reg : 'z;

   p_rdslot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && s1_op == OP_RD |=> drv_reg);

   p_wrslot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && s1_op == OP_WR |=> !drv_reg && s2_op == OP_WR);

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> $stable(q_reg) && $stable(drv_reg) && $stable(s2_addr));

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en && s1_op == OP_IDLE |=> !drv_reg && s2_op == OP_IDLE);

endmodule

// File: tb/nowait_sram_test.sv
`timescale 1ns/1ps
module nowait_sram_test;

   localparam int LANES  = 4;
   localparam int LANE_W = 9;
   localparam int DEPTH  = 64;
   localparam int NUM_CS = 3;
   localparam int AW     = $clog2(DEPTH);
   localparam int DW     = LANES * LANE_W;

   typedef struct packed {
      logic             adv;
      logic             sel;
      logic             wr;
      logic             lin;
      logic [AW-1:0]    a;
      logic [LANES-1:0] m;
      logic [DW-1:0]    d;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b1, 1'b1, 1'b1, 6'h04, 4'hF, 36'h123456789},
      '{1'b0, 1'b1, 1'b0, 1'b1, 6'h04, 4'h0, 36'h000000000},
      '{1'b0, 1'b1, 1'b1, 1'b1, 6'h05, 4'hF, 36'h0ABCDEF01},
      '{1'b0, 1'b1, 1'b0, 1'b1, 6'h05, 4'h0, 36'h000000000},
      '{1'b0, 1'b1, 1'b1, 1'b1, 6'h04, 4'h5, 36'hFFFFFFFFF},
      '{1'b0, 1'b1, 1'b0, 1'b1, 6'h04, 4'h0, 36'h000000000},
      '{1'b0, 1'b1, 1'b1, 1'b0, 6'h09, 4'hF, 36'h111111111},
      '{1'b1, 1'b0, 1'b0, 1'b0, 6'h3F, 4'hF, 36'h222222222},
      '{1'b1, 1'b1, 1'b0, 1'b0, 6'h00, 4'h3, 36'h333333333},
      '{1'b1, 1'b1, 1'b0, 1'b0, 6'h00, 4'h8, 36'h444444444},
      '{1'b0, 1'b1, 1'b0, 1'b1, 6'h0A, 4'h0, 36'h000000000},
      '{1'b1, 1'b0, 1'b1, 1'b1, 6'h00, 4'hF, 36'h000000000},
      '{1'b1, 1'b1, 1'b1, 1'b1, 6'h00, 4'hF, 36'h000000000},
      '{1'b1, 1'b1, 1'b0, 1'b1, 6'h00, 4'h0, 36'h000000000},
      '{1'b0, 1'b0, 1'b1, 1'b1, 6'h05, 4'hF, 36'h000000000},
      '{1'b1, 1'b1, 1'b1, 1'b1, 6'h05, 4'hF, 36'h000000000},
      '{1'b0, 1'b1, 1'b0, 1'b1, 6'h05, 4'h0, 36'h000000000},
      '{1'b0, 1'b1, 1'b1, 1'b1, 6'h05, 4'h0, 36'h0DEADBEEF},
      '{1'b0, 1'b1, 1'b0, 1'b1, 6'h05, 4'h0, 36'h000000000},
      '{1'b0, 1'b1, 1'b0, 1'b1, 6'h04, 4'h0, 36'h000000000}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clk_en = 1'b1;
   logic [NUM_CS-1:0] cs = '0;
   logic             adv = 1'b0;
   logic             wr = 1'b0;
   logic [LANES-1:0] lane_we = '0;
   logic             order_lin = 1'b1;
   logic             oe = 1'b1;
   logic             sleep = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic             tb_drv = 1'b0;
   logic [DW-1:0]    tb_dat = '0;
   wire  [DW-1:0]    dq;
   logic             dq_drv;

   assign dq = tb_drv ? tb_dat : 'z;

   always #2.5 clk = ~clk;

   nowait_sram #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH), .NUM_CS(NUM_CS)) uut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cs(cs), .adv(adv), .wr(wr),
      .lane_we(lane_we), .order_lin(order_lin), .oe(oe), .sleep(sleep),
      .addr(addr), .dq(dq), .dq_drv(dq_drv)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [DW-1:0] ref_mem [DEPTH];
   int            kind [4];
   logic [DW-1:0] ev   [4];
   logic [DW-1:0] wd   [4];
   string         tags [4];
   int            cyc = 0;
   bit            b_act = 1'b0;
   bit            b_wr = 1'b0;
   logic [AW-1:0] b_base = '0;
   logic [1:0]    b_cnt = 2'd0;

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk1(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] c, input logic lin);
      logic [1:0] sum;
      sum = s + c;
      return lin ? sum : (s ^ c);
   endfunction

   function automatic string vtag(input int k);
      case (k)
         1, 19:          return "R3";
         3:              return "R2";
         5, 17, 18:      return "R4";
         7, 8, 9:        return "R6";
         10, 11, 12, 13: return "R7";
         14, 15:         return "R9";
         16:             return "R1";
         default:        return "R8";
      endcase
   endfunction

   // one enabled cycle: present v, model it, serve or check the slot of two cycles ago
   task automatic issue(input vec_t v, input string tg);
      int j;
      int p;
      logic [AW-1:0] oa;
      j  = cyc % 4;
      p  = (cyc + 2) % 4;
      oa = '0;
      adv = v.adv; cs = v.sel ? '1 : 3'b110; wr = v.wr;
      order_lin = v.lin; addr = v.a; lane_we = v.m;
      kind[j] = 0;
      tags[j] = tg;
      if (!v.adv) begin
         if (v.sel) begin
            b_act = 1'b1; b_wr = v.wr; b_base = v.a; b_cnt = 2'd0;
            kind[j] = v.wr ? 2 : 1;
            oa = v.a;
         end else begin
            b_act = 1'b0;
         end
      end else if (b_act) begin
         b_cnt = b_cnt + 2'd1;
         kind[j] = b_wr ? 2 : 1;
         oa = {b_base[AW-1:2], exp_low(b_base[1:0], b_cnt, v.lin)};
      end
      if (kind[j] == 2) begin
         wd[j] = v.d;
         for (int i = 0; i < LANES; i++)
            if (v.m[i]) ref_mem[oa][i*LANE_W +: LANE_W] = v.d[i*LANE_W +: LANE_W];
      end else if (kind[j] == 1) begin
         ev[j] = ref_mem[oa];
      end
      if (cyc >= 2 && kind[p] == 2) begin
         tb_drv = 1'b1;
         tb_dat = wd[p];
      end else begin
         tb_drv = 1'b0;
      end
      #1;
      if (cyc >= 2) begin
         if (kind[p] == 1) begin
            chk({tags[p], " read data"}, dq, ev[p]);
            chk1({tags[p], " driver on in read slot"}, dq_drv, 1'b1);
         end else begin
            chk1({tags[p], " driver off in non-read slot"}, dq_drv, 1'b0);
         end
      end
      step();
      cyc++;
   endtask

   task automatic set_idle();
      adv = 1'b0; cs = 3'b110; wr = 1'b0; lane_we = '0;
   endtask

   task automatic set_read(input logic [AW-1:0] a);
      adv = 1'b0; cs = '1; wr = 1'b0; lane_we = '0; addr = a;
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      // R12: reset state
      step();
      step();
      chk1("R12 driver off under reset", dq_drv, 1'b0);
      rst_n = 1'b1;
      step();
      chk1("R12 driver off after reset", dq_drv, 1'b0);

      // fill every word through the bus
      for (int a = 0; a < DEPTH; a++) begin
         vec_t v;
         v = '0;
         v.sel = 1'b1; v.wr = 1'b1; v.lin = 1'b1;
         v.a = AW'(a); v.m = '1;
         v.d = {LANES{9'(a * 7 + 3)}};
         issue(v, "R2");
      end

      // vector table, then two flush cycles
      for (int k = 0; k < NV + 2; k++) begin
         if (k < NV) issue(VECS[k], vtag(k));
         else        issue('0, "R9");
      end

      // R5: stall holds output; stalled inputs ignored; R10 async oe
      tb_drv = 1'b0;
      set_read(6'h05);
      step();
      set_idle();
      step();
      chk1("R1 driver on before stall", dq_drv, 1'b1);
      chk("R1 data before stall", dq, ref_mem[5]);
      clk_en = 1'b0;
      adv = 1'b0; cs = '1; wr = 1'b1; lane_we = '1; addr = 6'h05;
      for (int s = 0; s < 3; s++) begin
         step();
         chk1("R5 driver held in stall", dq_drv, 1'b1);
         chk("R5 data held in stall", dq, ref_mem[5]);
      end
      oe = 1'b0;
      #1;
      chk1("R10 oe low releases bus", dq_drv, 1'b0);
      oe = 1'b1;
      #1;
      chk1("R10 oe high restores bus", dq_drv, 1'b1);
      set_idle();
      clk_en = 1'b1;
      step();
      chk1("R5 slot after stall idle", dq_drv, 1'b0);
      set_read(6'h05);
      step();
      set_idle();
      step();
      chk("R5 word untouched by stalled write", dq, ref_mem[5]);

      // R11: sleep
      sleep = 1'b1;
      set_read(6'h04);
      step();
      chk1("R11 driver off asleep", dq_drv, 1'b0);
      step();
      chk1("R11 driver off asleep", dq_drv, 1'b0);
      sleep = 1'b0;
      set_idle();
      #1;
      chk1("R11 bus undriven on wake", dq_drv, 1'b0);
      step();
      chk1("R11 bus undriven after wake", dq_drv, 1'b0);
      set_read(6'h04);
      step();
      set_idle();
      step();
      chk("R11 contents retained", dq, ref_mem[4]);

      // R12: reset releases the bus
      set_read(6'h04);
      step();
      set_idle();
      step();
      rst_n = 1'b0;
      #1;
      chk1("R12 reset releases bus", dq_drv, 1'b0);
      step();
      rst_n = 1'b1;
      step();
      chk1("R12 idle after reset", dq_drv, 1'b0);

      if (!done) begin
         done = 1'b1;
         report();
         $finish;
      end
   end

   initial begin
      #(5 * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         report();
         $finish;
      end
   end

endmodule